// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits on the host side of a memory controller and classifies each host access that falls in the upper part of the first megabyte. For every address it decides whether the access is served by main DRAM or passed on to the legacy bus. It also raises a flag when a write must be dropped because the target range is shadowed read-only. Addresses outside the window always go to DRAM.

The decision depends on a small set of byte-wide attribute registers. One two-bit code covers the 64 KB BIOS area at the top of the window. Twelve more codes cover consecutive 16 KB expansion segments, packed two to a byte. A separate control byte governs the 128 KB graphics window together with a system-management-mode input. Attribute registers are loaded through a byte write port and take effect on the cycle after the write. The access path itself is combinational from the stored attributes.

Top module: `legacy_mem_decoder`

## Requirements
- R1: An address below 0xA0000 or at or above 0x100000 selects DRAM (`to_dram`=1, `wr_block`=0), whatever the attributes are.
- R2: The range 0xF0000..0xFFFFF uses the two-bit code held in bits [5:4] of the byte written at offset 0x59. The other bits of that byte have no effect.
- R3: Segment k (k = 0..11) spans 0xC0000 + k*0x4000 up to 16 KB. Its code is stored at offset 0x5A + k/2: even k uses byte bits [1:0], odd k uses bits [5:4]. Bits [3:2] and [7:6] are ignored.
- R4: Code 3 sends both reads and writes to DRAM, with no write block.
- R5: Code 1 sends reads to DRAM. A write is not sent to DRAM and raises `wr_block`.
- R6: Codes 0 and 2 send reads and writes to the legacy bus (`to_dram`=0, `wr_block`=0).
- R7: The range 0xA0000..0xBFFFF selects DRAM when bit 6 of the byte at offset 0x72 is set, or when `smm_act` is high and bit 3 of that byte is set. Otherwise it selects the legacy bus and `wr_block` stays 0.
- R8: On reset, the byte at offset 0x72 becomes 0x02 and every other attribute code becomes 0. The whole 0xA0000..0xFFFFF window then goes to the legacy bus, even with `smm_act` high.
- R9: A configuration write changes the decode only from the clock edge that captures it. A write to any offset other than 0x59..0x5F or 0x72 leaves the decode unchanged.
- R10: `wr_block` is never asserted for a read (`acc_wr`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | ADDR_W (32) | Host access address |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| smm_act | input | 1 | System-management mode active |
| to_dram | output | 1 | Access is served by DRAM |
| wr_block | output | 1 | Write must be discarded (read-only shadow) |

## Verification
The assertions assume that the access inputs are stable over a clock period. They also assume that a configuration write is a single-cycle strobe whose data is valid while the strobe is high. Output stability is therefore checked only across cycles where no write was captured and the address, direction and mode inputs did not move. The bench drives every input at the falling edge and holds it for at least a full cycle. It issues each configuration write as a single one-cycle pulse. It samples the outputs shortly after the inputs settle, so every check sees the attributes captured at the preceding rising edge.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    // two-bit attribute codes
    typedef enum logic [1:0] {
        ATTR_BUS0 = 2'd0,
        ATTR_RO   = 2'd1,
        ATTR_BUS2 = 2'd2,
        ATTR_RW   = 2'd3
    } attr_e;

    // address classes inside the decoded window
    typedef enum logic [1:0] {
        RGN_OUT  = 2'd0,
        RGN_VGA  = 2'd1,
        RGN_SEG  = 2'd2,
        RGN_BIOS = 2'd3
    } region_e;

    // configuration offsets; the decoder behaviour depends on these
    localparam logic [7:0] OFS_BIOS     = 8'h59;
    localparam logic [7:0] OFS_SEG_BASE = 8'h5A;
    localparam logic [7:0] OFS_SMRAM    = 8'h72;
    localparam logic [7:0] SMRAM_RST    = 8'h02;

    // control bit positions inside the graphics-window byte
    localparam int SMRAM_SMM_BIT  = 3;
    localparam int SMRAM_OPEN_BIT = 6;

    // window boundaries
    localparam logic [31:0] VGA_LO  = 32'h000A_0000;
    localparam logic [31:0] SEG_LO  = 32'h000C_0000;
    localparam logic [31:0] BIOS_LO = 32'h000F_0000;
    localparam logic [31:0] WIN_TOP = 32'h0010_0000;

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs
    import lmd_pkg::*;
#(
    parameter int NSEG = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [7:0]                         cfg_addr,
    input  logic [7:0]                         cfg_wdata,
    output logic [1:0]                         bios_attr,
    output logic [((NSEG + 1) / 2)-1:0][7:0]   seg_bytes,
    output logic [7:0]                         smram
);

    localparam int NBYTES = (NSEG + 1) / 2;

    typedef struct packed {
        logic [1:0]             bios;
        logic [NBYTES-1:0][7:0] segb;
        logic [7:0]             smram;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr == OFS_BIOS) begin
                st_d.bios = cfg_wdata[5:4];
            end
            if (cfg_addr == OFS_SMRAM) begin
                st_d.smram = cfg_wdata;
            end
            for (int b = 0; b < NBYTES; b++) begin
                if (cfg_addr == OFS_SEG_BASE + 8'(b)) begin
                    st_d.segb[b] = cfg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bios  <= 2'b00;
            st_q.segb  <= '0;
            st_q.smram <= SMRAM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bios_attr = st_q.bios;
    assign seg_bytes = st_q.segb;
    assign smram     = st_q.smram;

endmodule

// File: rtl/lmd_region.sv
module lmd_region
    import lmd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NSEG      = 12,
    parameter int SEG_SHIFT = 14
) (
    input  logic [ADDR_W-1:0]            addr,
    output region_e                      region,
    output logic [$clog2(NSEG)-1:0]      seg_idx
);

    localparam int          IDX_W  = $clog2(NSEG);
    localparam logic [31:0] SEG_HI = SEG_LO + 32'(NSEG) * (32'd1 << SEG_SHIFT);

    logic [ADDR_W-1:0] seg_off;

    always_comb begin
        seg_off = addr - ADDR_W'(SEG_LO);
        seg_idx = seg_off[SEG_SHIFT +: IDX_W];
        if (addr >= ADDR_W'(VGA_LO) && addr < ADDR_W'(SEG_LO)) begin
            region = RGN_VGA;
        end else if (addr >= ADDR_W'(SEG_LO) && addr < ADDR_W'(SEG_HI)) begin
            region = RGN_SEG;
        end else if (addr >= ADDR_W'(BIOS_LO) && addr < ADDR_W'(WIN_TOP)) begin
            region = RGN_BIOS;
        end else begin
            region = RGN_OUT;
        end
    end

endmodule

// File: rtl/lmd_route.sv
module lmd_route
    import lmd_pkg::*;
(
    input  region_e    region,
    input  logic [1:0] attr,
    input  logic       smm_act,
    input  logic       vga_smm_en,
    input  logic       vga_open,
    input  logic       acc_wr,
    output logic       to_dram,
    output logic       wr_block
);

    always_comb begin
        to_dram  = 1'b0;
        wr_block = 1'b0;
        unique case (region)
            RGN_OUT: begin
                to_dram = 1'b1;
            end
            RGN_VGA: begin
                to_dram = vga_open | (smm_act & vga_smm_en);
            end
            default: begin
                unique case (attr_e'(attr))
                    ATTR_RW: to_dram = 1'b1;
                    ATTR_RO: begin
                        to_dram  = ~acc_wr;
                        wr_block = acc_wr;
                    end
                    default: to_dram = 1'b0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lmd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NSEG      = 12,
    parameter int SEG_SHIFT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              smm_act,
    output logic              to_dram,
    output logic              wr_block
);

    localparam int NBYTES = (NSEG + 1) / 2;
    localparam int IDX_W  = $clog2(NSEG);

    logic [1:0]             bios_attr;
    logic [NBYTES-1:0][7:0] seg_bytes;
    logic [7:0]             smram;
    region_e                region;
    logic [IDX_W-1:0]       seg_idx;
    logic [NSEG-1:0][1:0]   seg_attr;
    logic [1:0]             sel_attr;

    lmd_cfg_regs #(.NSEG(NSEG)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bios_attr (bios_attr),
        .seg_bytes (seg_bytes),
        .smram     (smram)
    );

    lmd_region #(.ADDR_W(ADDR_W), .NSEG(NSEG), .SEG_SHIFT(SEG_SHIFT)) u_rgn (
        .addr    (acc_addr),
        .region  (region),
        .seg_idx (seg_idx)
    );

    // unpack two codes per byte: even segment low nibble, odd segment high nibble
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign seg_attr[g] = seg_bytes[g / 2][(g % 2) * 4 +: 2];
    end

    always_comb begin
        if (region == RGN_SEG && 32'(seg_idx) < NSEG) begin
            sel_attr = seg_attr[seg_idx];
        end else begin
            sel_attr = bios_attr;
        end
    end

    lmd_route u_route (
        .region     (region),
        .attr       (sel_attr),
        .smm_act    (smm_act),
        .vga_smm_en (smram[SMRAM_SMM_BIT]),
        .vga_open   (smram[SMRAM_OPEN_BIT]),
        .acc_wr     (acc_wr),
        .to_dram    (to_dram),
        .wr_block   (wr_block)
    );

endmodule

// File: rtl/lmd_chk.sv
module lmd_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic              smm_act,
    input logic              to_dram,
    input logic              wr_block
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic outside, in_vga;
    assign outside = (acc_addr < ADDR_W'(32'h000A_0000)) || (acc_addr >= ADDR_W'(32'h0010_0000));
    assign in_vga  = (acc_addr >= ADDR_W'(32'h000A_0000)) && (acc_addr < ADDR_W'(32'h000C_0000));

    AST_OUTSIDE_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> (to_dram && !wr_block)); // R1

    AST_BLOCK_NOT_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> !to_dram); // R5

    AST_READ_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |-> !wr_block); // R10

    AST_VGA_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_we && cfg_addr == 8'h72 && cfg_wdata[6]) && in_vga) |-> to_dram); // R7

    AST_HOLD_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cfg_we) && $stable(acc_addr) && $stable(acc_wr) && $stable(smm_act))
        |-> ($stable(to_dram) && $stable(wr_block))); // R9

endmodule

bind legacy_mem_decoder lmd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .smm_act   (smm_act),
    .to_dram   (to_dram),
    .wr_block  (wr_block)
);

// File: tb/legacy_mem_decoder_tb.sv
module legacy_mem_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_wr = 1'b0;
    logic        smm_act = 1'b0;
    logic        to_dram;
    logic        wr_block;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    legacy_mem_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .smm_act   (smm_act),
        .to_dram   (to_dram),
        .wr_block  (wr_block)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic        we;
        logic [7:0]  ca;
        logic [7:0]  cd;
        logic [31:0] addr;
        logic        wr;
        logic        smm;
        logic        ed;
        logic        eb;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'd8,  1'b0, 8'h00, 8'h00, 32'h000F8000, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 bios legacy
        '{8'd8,  1'b0, 8'h00, 8'h00, 32'h000A0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 vga closed with smm
        '{8'd1,  1'b0, 8'h00, 8'h00, 32'h00000500, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 low
        '{8'd1,  1'b0, 8'h00, 8'h00, 32'h00100000, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 high write
        '{8'd4,  1'b1, 8'h59, 8'h30, 32'h000F0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 R4
        '{8'd5,  1'b1, 8'h59, 8'h10, 32'h000FFFFF, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 write blocked
        '{8'd10, 1'b0, 8'h00, 8'h00, 32'h000FFFFF, 1'b0, 1'b0, 1'b1, 1'b0}, // R10 R5 read
        '{8'd6,  1'b1, 8'h59, 8'h23, 32'h000F4000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 R2 code 2
        '{8'd3,  1'b1, 8'h5A, 8'h31, 32'h000C0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 seg0 ro
        '{8'd3,  1'b0, 8'h00, 8'h00, 32'h000C4000, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 seg1 rw
        '{8'd3,  1'b0, 8'h00, 8'h00, 32'h000C3FFF, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 seg0 top read
        '{8'd3,  1'b1, 8'h5F, 8'hC3, 32'h000E8000, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 seg10
        '{8'd3,  1'b0, 8'h00, 8'h00, 32'h000EC000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 seg11 ignores [7:6]
        '{8'd6,  1'b1, 8'h5D, 8'h20, 32'h000DC000, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 seg7 code 2
        '{8'd7,  1'b1, 8'h72, 8'h08, 32'h000A0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 no smm
        '{8'd7,  1'b0, 8'h00, 8'h00, 32'h000BFFFF, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 smm
        '{8'd7,  1'b1, 8'h72, 8'h40, 32'h000B0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 open
        '{8'd9,  1'b1, 8'h60, 8'hFF, 32'h000E8000, 1'b0, 1'b0, 1'b1, 1'b0}  // R9 other offset
    };

    task automatic check(input string tag, input logic ed, input logic eb);
        n_chk++;
        if (to_dram !== ed || wr_block !== eb) begin
            n_err++;
            $display("FAIL %s: to_dram/wr_block = %b/%b expected %b/%b",
                     tag, to_dram, wr_block, ed, eb);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R8 state while reset is held
        acc_addr = 32'h000F0000;
        #3;
        check("R8 in reset", 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) cfg_write(VEC[i].ca, VEC[i].cd);
            else           @(negedge clk);
            acc_addr = VEC[i].addr;
            acc_wr   = VEC[i].wr;
            smm_act  = VEC[i].smm;
            #1;
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].ed, VEC[i].eb);
        end

        // R9: a write is not visible until the capturing edge
        @(negedge clk);
        acc_addr  = 32'h000F0000;
        acc_wr    = 1'b0;
        smm_act   = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 8'h59;
        cfg_wdata = 8'h30;
        #1;
        check("R9 before edge", 1'b0, 1'b0);
        @(posedge clk);
        #1;
        check("R9 after edge", 1'b1, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0;

        // R4 write to code 3 region after timing test
        acc_wr = 1'b1;
        #1;
        check("R4 bios write", 1'b1, 1'b0);

        // R8: reset mid-run restores legacy routing everywhere
        @(negedge clk);
        rst_n    = 1'b0;
        acc_addr = 32'h000E8000;
        acc_wr   = 1'b1;
        #1;
        check("R8 seg after reset", 1'b0, 1'b0);
        acc_addr = 32'h000B0000;
        smm_act  = 1'b1;
        #1;
        check("R8 vga after reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R8 vga after release", 1'b0, 1'b0);

        // R1 boundary just below the window
        acc_addr = 32'h0009FFFF;
        #1;
        check("R1 below window", 1'b1, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule